// File: doc/BRIEF.md
# Watchdog Timer

A memory-mapped watchdog peripheral. Software selects a timeout from sixteen power-of-two periods and starts the timer. While the timer runs, software must write a fixed key to the restart register before the count reaches zero. If it does not, the block either requests a system reset at once, or first raises an interrupt and requests the reset only if that interrupt is still pending at the next expiry.

The register port is a plain single-cycle slave with no wait states. A write takes effect at the clock edge where `bus_wr` is high. Read data is a combinational function of `bus_addr` and the register state. A read has a side effect only at the interrupt-acknowledge offset, and that side effect happens at the edge where `bus_rd` is high. The register port has no valid/ready handshake and never applies back-pressure. The shortest period is `2^MIN_EXP` cycles, so a bench can shrink every period without changing the behaviour.

Top module: `wdog_timer`

## Requirements
- R1: After reset, control, timeout-select, count and status all read 0, and `irq` and `sys_rst_req` are low. While disabled, the count reads 0 and `irq` stays low.
- R2: Writing 1 to control bit 0 (offset 0x00) enables the timer and latches the response mode from bit 1. After that, no control write can clear the enable bit or change the mode. Only the block reset disables the timer.
- R3: The timeout-select register (offset 0x04) stores write-data bits 7:0. Bits 3:0 are the normal code and bits 7:4 are the first-period code. Bits 31:8 read as 0.
- R4: A code n gives a period of `2^(MIN_EXP+n)` cycles. The period that starts with the enabling write uses the first-period code. Every later reload uses the normal code.
- R5: Offset 0x08 reads the live count. The count is period−1 right after a load and falls by one per cycle.
- R6: Writing exactly 0x76 to offset 0x0C while enabled reloads the count with normal period−1. Any other value written there leaves the count unchanged.
- R7: In mode 0 (bit 1 = 0), the cycle in which the count is 0 without a restart is an expiry. The count reloads and `sys_rst_req` goes high from the next cycle for exactly RST_CYCLES cycles.
- R8: In mode 1, an expiry with no interrupt pending sets status bit 0 (offset 0x10) and `irq`. An expiry while the interrupt is pending produces the reset pulse instead.
- R9: A read of offset 0x14 clears status bit 0 and `irq` and leaves the count untouched.
- R10: Offsets 0xF4, 0xF8 and 0xFC return the parameters ID_CFG, ID_VER and ID_KIND, and writes to them are ignored. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (needed only for acknowledge side effect) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| sys_rst_req | output | 1 | System reset request pulse |
| irq | output | 1 | Timeout interrupt, level |

## Verification
A wrong count shows on the next read of offset 0x08. It also shifts the expiry, so `irq` or `sys_rst_req` rises a cycle early or late, which the bench catches on that very cycle because it compares both outputs with its model on every clock. A corrupted pending flag turns an interrupt into a reset, or the reverse, at the next expiry. A lost enable latch silences both outputs at the next period boundary. The bench measures delays from enabling to the interrupt and to the reset, and the pulse width, in whole cycles against the power-of-two periods.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;
  localparam int CODE_W  = 4;
  localparam int NCODES  = 1 << CODE_W;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_TMO  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_CNT  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_KICK = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_ACK  = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_ID0  = 8'hF4;
  localparam logic [ADDR_W-1:0] OFS_ID1  = 8'hF8;
  localparam logic [ADDR_W-1:0] OFS_ID2  = 8'hFC;

  localparam logic [DATA_W-1:0] KICK_KEY = 32'h0000_0076;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_MODE_BIT = 1;

  typedef enum logic {
    RESP_RESET    = 1'b0,
    RESP_IRQ_FIRST = 1'b1
  } resp_mode_e;

  typedef struct packed {
    logic start;
    logic kick;
    logic ack;
  } wdt_evt_t;
endpackage

// File: rtl/wdt_regbank.sv
module wdt_regbank
  import wdt_pkg::*;
#(
  parameter int CNT_W = 31,
  parameter logic [31:0] ID_CFG  = 32'h0,
  parameter logic [31:0] ID_VER  = 32'h0,
  parameter logic [31:0] ID_KIND = 32'h0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic [CNT_W-1:0]   count,
  input  logic               irq_stat,
  output logic               en_q,
  output resp_mode_e         mode_q,
  output logic [2*CODE_W-1:0] tmo_q,
  output wdt_evt_t           evt,
  output logic [DATA_W-1:0]  bus_rdata
);
  logic wr_ctrl, wr_tmo;

  assign wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
  assign wr_tmo  = bus_wr && (bus_addr == OFS_TMO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mode_q <= RESP_RESET;
      tmo_q  <= '0;
    end else begin
      if (wr_ctrl && !en_q) begin
        en_q   <= bus_wdata[CTRL_EN_BIT];
        mode_q <= resp_mode_e'(bus_wdata[CTRL_MODE_BIT]);
      end
      if (wr_tmo) begin
        tmo_q <= bus_wdata[2*CODE_W-1:0];
      end
    end
  end

  always_comb begin
    evt       = '0;
    evt.start = wr_ctrl && bus_wdata[CTRL_EN_BIT] && !en_q;
    evt.kick  = bus_wr && (bus_addr == OFS_KICK) && (bus_wdata == KICK_KEY) && en_q;
    evt.ack   = bus_rd && (bus_addr == OFS_ACK);
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFS_CTRL: begin
        bus_rdata[CTRL_EN_BIT]   = en_q;
        bus_rdata[CTRL_MODE_BIT] = mode_q;
      end
      OFS_TMO:  bus_rdata[2*CODE_W-1:0] = tmo_q;
      OFS_CNT:  bus_rdata = DATA_W'(count);
      OFS_STAT: bus_rdata[0] = irq_stat;
      OFS_ID0:  bus_rdata = ID_CFG;
      OFS_ID1:  bus_rdata = ID_VER;
      OFS_ID2:  bus_rdata = ID_KIND;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int MIN_EXP = 16,
  parameter int CNT_W   = MIN_EXP + NCODES - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              start,
  input  logic              kick,
  input  logic [CODE_W-1:0] first_code,
  input  logic [CODE_W-1:0] norm_code,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  reload_val,
  output logic              expire
);
  logic [CNT_W-1:0] per_tab [NCODES];

  for (genvar g = 0; g < NCODES; g++) begin : g_period
    localparam longint unsigned PER = longint'(1) << (MIN_EXP + g);
    assign per_tab[g] = CNT_W'(PER - 1);
  end

  assign reload_val = per_tab[norm_code];
  assign expire     = en && !kick && (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (start) begin
      count <= per_tab[first_code];
    end else if (en) begin
      if (kick || expire) count <= reload_val;
      else                count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/wdt_resp.sv
module wdt_resp
  import wdt_pkg::*;
#(
  parameter int RST_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       expire,
  input  resp_mode_e mode,
  input  logic       ack,
  output logic       irq_stat,
  output logic       sys_rst_req
);
  localparam int RC_W = $clog2(RST_CYCLES + 1);

  logic [RC_W-1:0] rst_left;
  logic            fire_rst, raise_irq;

  assign raise_irq = expire && (mode == RESP_IRQ_FIRST) && !irq_stat;
  assign fire_rst  = expire && !raise_irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_stat <= 1'b0;
      rst_left <= '0;
    end else begin
      if (raise_irq)  irq_stat <= 1'b1;
      else if (ack)   irq_stat <= 1'b0;

      if (fire_rst)             rst_left <= RC_W'(RST_CYCLES);
      else if (rst_left != '0)  rst_left <= rst_left - 1'b1;
    end
  end

  assign sys_rst_req = (rst_left != '0);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdt_pkg::*;
#(
  parameter int MIN_EXP    = 16,
  parameter int RST_CYCLES = 8,
  parameter logic [31:0] ID_CFG  = 32'h0000_0010,
  parameter logic [31:0] ID_VER  = 32'h0001_0200,
  parameter logic [31:0] ID_KIND = 32'h5744_0001
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        sys_rst_req,
  output logic        irq
);
  localparam int CNT_W = MIN_EXP + NCODES - 1;

  logic               en_q;
  resp_mode_e         mode_q;
  logic [2*CODE_W-1:0] tmo_q;
  wdt_evt_t           evt;
  logic [CNT_W-1:0]   count;
  logic [CNT_W-1:0]   reload_val;
  logic               expire;
  logic               irq_stat;

  wdt_regbank #(
    .CNT_W(CNT_W), .ID_CFG(ID_CFG), .ID_VER(ID_VER), .ID_KIND(ID_KIND)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .count(count), .irq_stat(irq_stat),
    .en_q(en_q), .mode_q(mode_q), .tmo_q(tmo_q), .evt(evt),
    .bus_rdata(bus_rdata)
  );

  wdt_counter #(.MIN_EXP(MIN_EXP), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en_q), .start(evt.start), .kick(evt.kick),
    .first_code(tmo_q[2*CODE_W-1:CODE_W]), .norm_code(tmo_q[CODE_W-1:0]),
    .count(count), .reload_val(reload_val), .expire(expire)
  );

  wdt_resp #(.RST_CYCLES(RST_CYCLES)) u_resp (
    .clk(clk), .rst_n(rst_n), .expire(expire), .mode(mode_q), .ack(evt.ack),
    .irq_stat(irq_stat), .sys_rst_req(sys_rst_req)
  );

  assign irq = irq_stat;
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int CNT_W = 31
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             mode,
  input logic             start,
  input logic             kick,
  input logic             ack,
  input logic             expire,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] reload_val,
  input logic             irq,
  input logic             sys_rst_req
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (count == '0 && !irq));

  assert_enable_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> en);

  assert_mode_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> $stable(mode));

  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !start && !kick && !expire) |=> count == CNT_W'($past(count) - 1'b1));

  assert_key_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> count == $past(reload_val));

  assert_reset_on_expiry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !mode) |=> sys_rst_req);

  assert_irq_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && mode && !irq) |=> irq);

  assert_second_expiry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && mode && irq) |=> sys_rst_req);

  assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !(expire && mode && !irq)) |=> !irq);
endmodule

bind wdog_timer wdt_checker #(.CNT_W(MIN_EXP + 15)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en_q), .mode(mode_q), .start(evt.start),
  .kick(evt.kick), .ack(evt.ack), .expire(expire), .count(count),
  .reload_val(reload_val), .irq(irq), .sys_rst_req(sys_rst_req)
);

// File: tb/tb_wdog_timer.sv
`timescale 1ns/1ps
module tb_wdog_timer;
  localparam int MIN_EXP = 4;
  localparam int RSTC    = 8;
  localparam logic [31:0] IDC = 32'h0000_0A04;
  localparam logic [31:0] IDV = 32'h0003_0100;
  localparam logic [31:0] IDK = 32'h7A11_0C0F;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic sys_rst_req, irq;

  int checks = 0, fails = 0, cyc = 0;

  wdog_timer #(.MIN_EXP(MIN_EXP), .RST_CYCLES(RSTC),
               .ID_CFG(IDC), .ID_VER(IDV), .ID_KIND(IDK)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sys_rst_req(sys_rst_req), .irq(irq));

  always #2 clk = ~clk;

  // behavioural reference model
  bit m_en, m_mode, m_stat;
  int m_tmo, m_cnt, m_rst_left;

  function automatic int per(int code);
    return 1 << (MIN_EXP + code);
  endfunction

  function automatic logic [31:0] model_rd(logic [7:0] a);
    case (a)
      8'h00: return {30'd0, m_mode, m_en};
      8'h04: return 32'(m_tmo);
      8'h08: return 32'(m_cnt);
      8'h10: return {31'd0, m_stat};
      8'hF4: return IDC;
      8'hF8: return IDV;
      8'hFC: return IDK;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_mode = 0; m_stat = 0; m_tmo = 0; m_cnt = 0; m_rst_left = 0;
    end else begin
      bit st, kk, ak, ex;
      st = bus_wr && bus_addr == 8'h00 && bus_wdata[0] && !m_en;
      kk = bus_wr && bus_addr == 8'h0C && bus_wdata == 32'h76 && m_en;
      ak = bus_rd && bus_addr == 8'h14;
      ex = m_en && !kk && m_cnt == 0;
      if (st) m_cnt = per(m_tmo >> 4) - 1;
      else if (m_en) m_cnt = (kk || ex) ? per(m_tmo & 15) - 1 : m_cnt - 1;
      if (ex && (!m_mode || m_stat)) m_rst_left = RSTC;
      else if (m_rst_left > 0) m_rst_left--;
      if (ex && m_mode && !m_stat) m_stat = 1;
      else if (ak) m_stat = 0;
      if (bus_wr && bus_addr == 8'h00 && !m_en) begin
        m_en = bus_wdata[0]; m_mode = bus_wdata[1];
      end
      if (bus_wr && bus_addr == 8'h04) m_tmo = int'(bus_wdata[7:0]);
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-clock comparison of the outputs
  always @(negedge clk) begin
    if (rst_n) begin
      check("R7 sys_rst_req vs model", 32'(sys_rst_req), 32'(m_rst_left > 0));
      check("R8 irq vs model", 32'(irq), 32'(m_stat));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, string tag, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    check(tag, v, model_rd(a));
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    logic [31:0] v;
    int n, w;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 irq after reset", 32'(irq), 0);
    check("R1 sys_rst_req after reset", 32'(sys_rst_req), 0);
    rd(8'h00, "R1 ctrl", v); check("R1 ctrl zero", v, 0);
    rd(8'h08, "R1 count", v); check("R1 count zero", v, 0);
    rd(8'h10, "R1 status", v);

    // R10 identification and unmapped
    rd(8'hF4, "R10 id cfg", v); check("R10 id cfg value", v, IDC);
    wr(8'hF8, 32'hFFFF_FFFF);
    rd(8'hF8, "R10 id ver after write", v); check("R10 id ver value", v, IDV);
    rd(8'hFC, "R10 id kind", v);
    rd(8'h18, "R10 unmapped", v); check("R10 unmapped zero", v, 0);

    // R3 timeout select: first code 2, normal code 1
    wr(8'h04, 32'hABCD_EF21);
    rd(8'h04, "R3 tmo readback", v); check("R3 tmo value", v, 32'h21);

    // R4/R5 enable in mode 0
    wr(8'h00, 32'h1);
    rd(8'h08, "R5 count after enable", v);
    rd(8'h08, "R5 count decrements", v);
    // R2 sticky
    wr(8'h00, 32'h2);
    rd(8'h00, "R2 ctrl after clear attempt", v); check("R2 enable kept", v, 32'h1);
    // R6 wrong and right keys
    wr(8'h0C, 32'h75);
    rd(8'h08, "R6 count after wrong key", v);
    wr(8'h0C, 32'h176);
    rd(8'h08, "R6 count after wide wrong key", v);
    wr(8'h0C, 32'h76);
    rd(8'h08, "R6 count after key", v);
    check("R6 reload normal period", v, 32'(per(1) - 2));
    // R7 reset pulse width
    n = 0;
    while (!sys_rst_req && n < 200) begin @(negedge clk); n++; end
    w = 0;
    while (sys_rst_req && w < 100) begin w++; @(negedge clk); end
    check("R7 pulse width", 32'(w), RSTC);
    rd(8'h08, "R7 count after expiry", v);

    // R2 only block reset disables
    do_reset();
    rd(8'h00, "R2 ctrl after block reset", v); check("R2 disabled", v, 0);

    // R4/R8 mode 1: first code 1 (32), normal code 0 (16)
    wr(8'h04, 32'h10);
    wr(8'h00, 32'h3);
    n = 0;
    while (!irq && n < 500) begin @(negedge clk); n++; end
    check("R4 first period length", 32'(n), 32'(per(1)));
    rd(8'h10, "R8 status set", v); check("R8 status bit", v, 1);
    check("R8 no reset on first expiry", 32'(sys_rst_req), 0);
    // R9 acknowledge
    rd(8'h14, "R9 ack read", v);
    check("R9 irq cleared", 32'(irq), 0);
    rd(8'h10, "R9 status cleared", v);
    rd(8'h08, "R9 count untouched", v);
    // next expiry raises irq, following one resets
    n = 0;
    while (!irq && n < 500) begin @(negedge clk); n++; end
    n = 0;
    while (!sys_rst_req && n < 500) begin @(negedge clk); n++; end
    check("R8 second expiry delay", 32'(n), 32'(per(0)));
    check("R8 irq still pending", 32'(irq), 1);
    rd(8'h08, "R5 count in mode 1", v);

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule